// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block conditions four asynchronous external interrupt pins for a downstream priority encoder. Each pin is brought into the clock domain through a multi-flop synchroniser. It is then qualified by a programmable sense mode: active-high level, rising edge, falling edge or active-low level. The result is one request line per pin.

In the edge modes a detected event is held in a sticky flag until software clears it. In the level modes the request tracks the synchronised pin. Every configuration field lives in a single 32-bit control word, written in one cycle and read back at any time. The same word carries a write-one-to-clear field for the edge flags and a global enable that gates all four requests. One further bit is brought out to choose how the critical interrupt is routed.

Top module: `ext_irq_sense`

## Requirements
- R1: With sense code 0 a pin requests while its synchronised value is 1. With sense code 3 it requests while its synchronised value is 0.
- R2: With sense code 1 a rising edge sets the pin's event flag. With sense code 2 a falling edge sets it. In these modes the request follows the flag and stays asserted after the pin returns to idle.
- R3: The sense code of pin n occupies control bits [23-2n:22-2n]. The enable of pin n is control bit 11-n, and 1 enables the pin. A disabled pin never requests.
- R4: Writing 1 to control bit 27-n clears the event flag of pin n, and writing 0 there leaves it unchanged. Reading bit 27-n returns the flag of pin n.
- R5: When an edge of pin n is detected in the same cycle as a clear write for pin n, the flag stays set.
- R6: While control bit 12 (global enable) is 0, all four requests are 0.
- R7: Control bit 0 drives the crit_route output. Reads return the stored bits 23:16, 12:8 and 0 as written, the flags in bits 27:24, and 0 in every other bit.
- R8: After reset the read value, all requests and crit_route are 0.
- R9: With the default two-stage synchroniser, a level-mode request changes on the second rising clock edge after the pin changes. An edge-mode request is set on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe for the control word |
| wr_data | input | 32 | Control word written when wr_en is 1 |
| rd_data | output | 32 | Current control word with event flags |
| pins | input | 4 | Asynchronous external interrupt pins |
| irq_req | output | 4 | Per-pin request to the priority encoder |
| crit_route | output | 1 | Critical-interrupt routing select |

## Verification
The bench targets the collision of a detected edge and a clear write in the same cycle. A design that lets the clear win drops an interrupt, and the flag reads back as 0. It also checks that an edge request persists after the pin returns idle; a design that treats edge modes as levels loses the request. Writes of 0 to the clear field are applied to a set flag: a plain register instead of write-one-to-clear would erase the flag. Bit placement is checked with a mixed-mode word, with partial enables and with the global enable off. A reversed pin index or a missing gate shows up as a wrong request pattern. The request is also sampled cycle by cycle against the synchroniser latency, to expose a missing or extra stage.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   typedef enum logic [1:0] {
      SENSE_LVL_HI = 2'd0,
      SENSE_RISE   = 2'd1,
      SENSE_FALL   = 2'd2,
      SENSE_LVL_LO = 2'd3
   } sense_e;

   localparam int CTRL_W     = 32;
   localparam int MAX_PINS   = 4;
   localparam int GLOBAL_BIT = 12;
   localparam int ROUTE_BIT  = 0;

   // field placement, decoded by software drivers
   function automatic int sense_lsb(input int n);
      return 22 - 2 * n;
   endfunction

   function automatic int enable_bit(input int n);
      return 11 - n;
   endfunction

   function automatic int clear_bit(input int n);
      return 27 - n;
   endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("ext_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import ext_irq_pkg::*;
#(
   parameter int NUM_PINS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CTRL_W-1:0]   wr_data,
   output sense_e              sense_o [NUM_PINS],
   output logic [NUM_PINS-1:0] en_o,
   output logic [NUM_PINS-1:0] clr_o,
   output logic                global_o,
   output logic                route_o
);
   sense_e              sense_q [NUM_PINS];
   logic [NUM_PINS-1:0] en_q;
   logic                global_q;
   logic                route_q;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_field
         localparam int SL = sense_lsb(gi);
         localparam int EB = enable_bit(gi);
         localparam int CB = clear_bit(gi);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sense_q[gi] <= SENSE_LVL_HI;
               en_q[gi]    <= 1'b0;
            end else if (wr_en) begin
               sense_q[gi] <= sense_e'(wr_data[SL+1:SL]);
               en_q[gi]    <= wr_data[EB];
            end
         end

         assign clr_o[gi]   = wr_en & wr_data[CB];
         assign sense_o[gi] = sense_q[gi];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         global_q <= 1'b0;
         route_q  <= 1'b0;
      end else if (wr_en) begin
         global_q <= wr_data[GLOBAL_BIT];
         route_q  <= wr_data[ROUTE_BIT];
      end
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   assign en_o     = en_q;
   assign global_o = global_q;
   assign route_o  = route_q;

   a_r7_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(route_o));
endmodule

// File: rtl/ext_irq_pin.sv
module ext_irq_pin
   import ext_irq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin_i,
   input  sense_e sense_i,
   input  logic   clr_i,
   input  logic   en_i,
   input  logic   global_i,
   output logic   req_o,
   output logic   flag_o
);
   logic s;
   logic prev_q;
   logic flag_q;
   logic edge_hit;
   logic level_act;
   logic active;

   ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (pin_i),
      .q_o  (s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= s;
   end

   always_comb begin
      edge_hit  = 1'b0;
      level_act = 1'b0;
      active    = 1'b0;
      unique case (sense_i)
         SENSE_LVL_HI: begin level_act = s;  active = level_act; end
         SENSE_LVL_LO: begin level_act = ~s; active = level_act; end
         SENSE_RISE:   begin edge_hit = s & ~prev_q; active = flag_q; end
         SENSE_FALL:   begin edge_hit = ~s & prev_q; active = flag_q; end
         default:      begin active = 1'b0; end
      endcase
   end

   // a fresh edge outranks a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= edge_hit | (flag_q & ~clr_i);
   end

   assign req_o  = active & en_i & global_i;
   assign flag_o = flag_q;

   a_r5_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> flag_q);
   a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);
   a_r4_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !edge_hit) |=> !flag_q);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
   import ext_irq_pkg::*;
#(
   parameter int NUM_PINS    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CTRL_W-1:0]   wr_data,
   output logic [CTRL_W-1:0]   rd_data,
   input  logic [NUM_PINS-1:0] pins,
   output logic [NUM_PINS-1:0] irq_req,
   output logic                crit_route
);
   generate
      if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad
         $error("ext_irq_sense: NUM_PINS out of range");
      end
   endgenerate

   sense_e              sense [NUM_PINS];
   logic [NUM_PINS-1:0] en;
   logic [NUM_PINS-1:0] clr;
   logic [NUM_PINS-1:0] flag;
   logic                glob;

   ext_irq_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .sense_o (sense),
      .en_o    (en),
      .clr_o   (clr),
      .global_o(glob),
      .route_o (crit_route)
   );

   genvar gp;
   generate
      for (gp = 0; gp < NUM_PINS; gp++) begin : g_pin
         ext_irq_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pins[gp]),
            .sense_i (sense[gp]),
            .clr_i   (clr[gp]),
            .en_i    (en[gp]),
            .global_i(glob),
            .req_o   (irq_req[gp]),
            .flag_o  (flag[gp])
         );
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      rd_data[GLOBAL_BIT] = glob;
      rd_data[ROUTE_BIT]  = crit_route;
      for (int n = 0; n < NUM_PINS; n++) begin
         rd_data[sense_lsb(n) +: 2] = sense[n];
         rd_data[enable_bit(n)]     = en[n];
         rd_data[clear_bit(n)]      = flag[n];
      end
   end

   a_r6_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !glob |-> (irq_req == '0));
   a_r3_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req & ~en) == '0);
endmodule

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  pins = '0;
   logic [3:0]  irq_req;
   logic        crit_route;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ext_irq_sense dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pins(pins), .irq_req(irq_req), .crit_route(crit_route)
   );

   // {ctrl, pins before, pins after}
   localparam logic [39:0] VEC [8] = '{
      {32'h0000_1F00, 4'b0000, 4'b1010},
      {32'h00FF_1F00, 4'b0000, 4'b1010},
      {32'h0055_1F00, 4'b0000, 4'b0110},
      {32'h00AA_1F00, 4'b1111, 4'b1100},
      {32'h0063_1F00, 4'b0010, 4'b0101},
      {32'h0000_0F00, 4'b0000, 4'b1111},
      {32'h0000_1500, 4'b0000, 4'b1111},
      {32'h0055_0F01, 4'b0000, 4'b1001}
   };

   function automatic logic [3:0] model_flag(logic [31:0] c, logic [3:0] b, logic [3:0] a);
      logic [3:0] f = '0;
      for (int n = 0; n < 4; n++) begin
         logic [1:0] m = c[22-2*n +: 2];
         if (m == 2'd1) f[n] = ~b[n] & a[n];
         if (m == 2'd2) f[n] = b[n] & ~a[n];
      end
      return f;
   endfunction

   function automatic logic [3:0] model_req(logic [31:0] c, logic [3:0] b, logic [3:0] a);
      logic [3:0] r = '0;
      logic [3:0] f = model_flag(c, b, a);
      for (int n = 0; n < 4; n++) begin
         logic [1:0] m = c[22-2*n +: 2];
         logic act = (m == 2'd0) ? a[n] : (m == 2'd3) ? ~a[n] : f[n];
         r[n] = act & c[11-n] & c[12];
      end
      return r;
   endfunction

   function automatic logic [31:0] model_rd(logic [31:0] c, logic [3:0] f);
      logic [31:0] v = c & 32'h00FF_1F01;
      for (int n = 0; n < 4; n++) v[27-n] = f[n];
      return v;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write(logic [31:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      // R8 reset state
      chk("R8 rd", rd_data, 32'h0);
      chk("R8 req", {28'h0, irq_req}, 32'h0);
      chk("R8 route", {31'h0, crit_route}, 32'h0);
      rst_n = 1'b1;
      idle(2);

      // table: R1 R2 R3 R6 R7
      for (int i = 0; i < 8; i++) begin
         logic [31:0] c = VEC[i][39:8];
         logic [3:0]  b = VEC[i][7:4];
         logic [3:0]  a = VEC[i][3:0];
         pins = b; idle(5);
         write(c | 32'h0F00_0000);
         idle(2);
         pins = a; idle(5);
         chk("R1/R2/R3/R6 req", {28'h0, irq_req}, {28'h0, model_req(c, b, a)});
         chk("R4/R7 rd", rd_data, model_rd(c, model_flag(c, b, a)));
         chk("R7 route", {31'h0, crit_route}, {31'h0, c[0]});
      end

      // R2 hold after idle, R4 W0 keeps / W1 clears
      pins = 4'b0000; idle(5);
      write(32'h0040_1800 | 32'h0F00_0000); // pin0 rising, enabled
      idle(2);
      pins = 4'b0001; idle(5);
      pins = 4'b0000; idle(5);
      chk("R2 hold after idle", {28'h0, irq_req}, 32'h1);
      write(32'h0040_1800);
      chk("R4 write0 keeps", {28'h0, irq_req}, 32'h1);
      chk("R4 flag readback", rd_data, 32'h0840_1800);
      write(32'h0840_1800);
      chk("R4 write1 clears", {28'h0, irq_req}, 32'h0);
      chk("R4 flag cleared", rd_data, 32'h0040_1800);

      // R5 edge and clear in same cycle
      @(negedge clk); pins = 4'b0001;
      @(negedge clk);
      @(negedge clk); wr_en = 1'b1; wr_data = 32'h0840_1800;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
      chk("R5 edge wins", {28'h0, irq_req}, 32'h1);
      chk("R5 flag set", rd_data, 32'h0840_1800);

      // R9 latency, level mode
      pins = 4'b0000; idle(3);
      write(32'h0F00_1800); // pin0 level high
      idle(2);
      @(negedge clk); pins = 4'b0001;
      @(negedge clk);
      chk("R9 level 1 edge", {28'h0, irq_req}, 32'h0);
      @(negedge clk);
      chk("R9 level 2 edges", {28'h0, irq_req}, 32'h1);

      // R9 latency, edge mode
      pins = 4'b0000; idle(4);
      write(32'h0F40_1800);
      idle(2);
      @(negedge clk); pins = 4'b0001;
      idle(2);
      chk("R9 edge 2 edges", {28'h0, irq_req}, 32'h0);
      @(negedge clk);
      chk("R9 edge 3 edges", {28'h0, irq_req}, 32'h1);

      finish_run();
   end
endmodule